// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster control signals for a display output clocked by the pixel clock: horizontal sync, vertical sync, data enable and an odd/even field indicator. A horizontal counter and a vertical counter both restart at zero on the leading edge of their sync pulse. All geometry is given as packed words: a total with a sync width, and active windows given as start and end positions. For interlaced scan the programmed vertical total covers both fields, and the second field has its own active window and its own vsync window.

Two line-flag comparators raise a one-cycle pulse at the first pixel of a chosen line, for interrupt use. Each pulse also sets a sticky status bit that software clears by writing a one. Sync and data-enable polarities can be programmed, and a standby control forces every output to its idle level. All configuration sits in a shadow copy. The shadow is captured on a config-done strobe and moved to the live set only at the next frame start, so a frame never runs with a mix of old and new settings.

Top module: `raster_timing_top`

## Requirements
- R1: While reset is held, and until the first configuration is applied, the live configuration is all zeros. With that configuration hsync, vsync and de sit at logic 1 (the idle level for active-low), field is 0 and both sticky bits are 0.
- R2: `cfg_h_timing` carries the line length in pixels in bits [31:16] and the hsync width in bits [15:0]. The horizontal count h runs from 0 to length-1 and then wraps. Internal hsync is active for h < width.
- R3: `cfg_v_timing` carries the frame length in lines in bits [31:16] and the vsync width in bits [15:0]. The line count v advances when h wraps and wraps after length-1. Internal vsync is active for v < width.
- R4: `cfg_h_active` and `cfg_v_active` each hold a start position in bits [31:16] and an end position in bits [15:0]. Internal de is active when start <= h < end on the horizontal axis and start <= v < end on the vertical axis.
- R5: When `cfg_interlace`=1, de is also active on lines inside the field-1 window `cfg_v_active_f1` (start in [31:16], end in [15:0]). Vsync is also active on lines inside `cfg_vsync_f1` (start in [31:16], end in [15:0]).
- R6: `field` is 1 on lines v >= the field-1 vsync start when interlaced. It is 0 in every other case, and always 0 in progressive mode.
- R7: `flag_pulse[0]` is high for exactly the one cycle where h=0 and v equals the last-active-line end minus 3, modulo 2^16. The end used is the field-1 window end when interlaced and the main window end otherwise.
- R8: `flag_pulse[1]` is high for exactly the one cycle where h=0 and v equals `cfg_flag1_line`.
- R9: A flag pulse sets `flag_sticky` for that flag on the next cycle. A one in `flag_clr` clears the bit on the next cycle. A pulse and a clear in the same cycle leave the bit set.
- R10: In `cfg_polarity`, bit 0 = 1 drives hsync active-high, bit 1 = 1 drives vsync active-high, and bit 3 = 1 drives de active-high. A 0 in any of these bits makes that output active-low. Bit 2 is ignored.
- R11: With `cfg_standby`=1, hsync, vsync and de are held at their idle levels while the counters and line flags keep running.
- R12: `cfg_done` captures every cfg_* input into the shadow. The captured set becomes live on the edge where the frame wraps (h and v both at their last position). Until then the outputs follow the old configuration. At that edge both counters restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Capture strobe for the shadow configuration |
| cfg_h_timing | input | 2*CW | Line length [31:16], hsync width [15:0] |
| cfg_h_active | input | 2*CW | Horizontal active start [31:16], end [15:0] |
| cfg_v_timing | input | 2*CW | Frame length in lines [31:16], vsync width [15:0] |
| cfg_v_active | input | 2*CW | Vertical active start [31:16], end [15:0] |
| cfg_v_active_f1 | input | 2*CW | Field-1 active line start [31:16], end [15:0] |
| cfg_vsync_f1 | input | 2*CW | Field-1 vsync start [31:16], end [15:0] |
| cfg_flag1_line | input | CW | Line number for line flag 1 |
| cfg_polarity | input | 4 | Polarity controls (bits 0, 1, 3) |
| cfg_interlace | input | 1 | 1 selects interlaced scan |
| cfg_standby | input | 1 | 1 blanks the outputs |
| flag_clr | input | 2 | Write-one-to-clear for the sticky flags |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | Field indicator |
| flag_pulse | output | 2 | Single-cycle line-flag pulses |
| flag_sticky | output | 2 | Sticky line-flag status |

## Verification
Hsync, vsync, de, field and the flag pulses decode the counter registers combinationally. Each of them is therefore due in the same cycle as the counter position it belongs to. The sticky bits are registered and lag their pulse or clear by one edge. A new configuration appears in the cycle after the frame-wrap edge, and that edge comes at the earliest one edge after the cfg_done edge. The bench keeps its own pixel index for the frame, its own live, pending and shadow configuration sets, and its own sticky state. It updates all of these at each rising edge using the rules above, and compares every output at the falling edge in between. Each result is thus checked in exactly the cycle it is due, across progressive, interlaced, standby and mixed-polarity frames and across the configuration switches between them.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int RTG_CW_DEF    = 16;
   localparam int RTG_NUM_FLAGS = 2;
   localparam int POL_HS        = 0;
   localparam int POL_VS        = 1;
   localparam int POL_DE        = 3;
   localparam int POL_W         = 4;
   localparam int FLAG0_BACKOFF = 3;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_done,
   input  logic         frame_wrap,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_live
);
   logic [W-1:0] shadow_q;
   logic         pending_q;

   if (W < 1) begin : g_w_chk
      $error("rtg_shadow: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q  <= '0;
         q_live    <= '0;
         pending_q <= 1'b0;
      end else begin
         if (frame_wrap && pending_q)
            q_live <= shadow_q;
         if (cfg_done)
            shadow_q <= d_in;
         pending_q <= cfg_done | (pending_q & ~frame_wrap);
      end
   end

   // R12: live configuration only moves on a frame wrap
   a_r12_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_wrap |=> $stable(q_live));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] h_tot,
   input  logic [CW-1:0] v_tot,
   output logic [CW-1:0] h_cnt,
   output logic [CW-1:0] v_cnt,
   output logic          frame_wrap
);
   localparam int XW = CW + 1;

   logic h_last, v_last;

   if (CW < 4) begin : g_cw_chk
      $error("rtg_counters: CW must be at least 4");
   end

   assign h_last     = (XW'(h_cnt) + XW'(1)) >= XW'(h_tot);
   assign v_last     = (XW'(v_cnt) + XW'(1)) >= XW'(v_tot);
   assign frame_wrap = h_last & v_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (h_last) begin
         h_cnt <= '0;
         v_cnt <= v_last ? '0 : v_cnt + 1'b1;
      end else begin
         h_cnt <= h_cnt + 1'b1;
      end
   end

   // R2: pixel count stays inside the programmed line
   a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (h_tot != '0) |-> (h_cnt < h_tot));
   // R3: line count stays inside the programmed frame
   a_r3_v_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (v_tot != '0) |-> (v_cnt < v_tot));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
   parameter int CW = 16,
   parameter int NF = rtg_pkg::RTG_NUM_FLAGS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CW-1:0]            h_cnt,
   input  logic [CW-1:0]            v_cnt,
   input  logic [CW-1:0]            h_sw,
   input  logic [CW-1:0]            h_st,
   input  logic [CW-1:0]            h_end,
   input  logic [CW-1:0]            v_sw,
   input  logic [CW-1:0]            v_st,
   input  logic [CW-1:0]            v_end,
   input  logic [CW-1:0]            v_st1,
   input  logic [CW-1:0]            v_end1,
   input  logic [CW-1:0]            vs1_st,
   input  logic [CW-1:0]            vs1_end,
   input  logic [CW-1:0]            flag1_line,
   input  logic [rtg_pkg::POL_W-1:0] pol,
   input  logic                     ilace,
   input  logic                     standby,
   output logic                     hsync,
   output logic                     vsync,
   output logic                     de,
   output logic                     field,
   output logic [NF-1:0]            flag_pulse
);
   import rtg_pkg::*;

   logic          hs_a, vs_a, de_a, hde, vde, line_start;
   logic [CW-1:0] last_end;
   logic [CW-1:0] flag_line [NF];

   if (NF != 2) begin : g_nf_chk
      $error("rtg_decode: exactly two line flags are supported");
   end

   assign hs_a = (h_cnt < h_sw) & ~standby;
   assign vs_a = ((v_cnt < v_sw) |
                  (ilace & (v_cnt >= vs1_st) & (v_cnt < vs1_end))) & ~standby;
   assign hde  = (h_cnt >= h_st) & (h_cnt < h_end);
   assign vde  = ((v_cnt >= v_st) & (v_cnt < v_end)) |
                 (ilace & (v_cnt >= v_st1) & (v_cnt < v_end1));
   assign de_a = hde & vde & ~standby;

   assign hsync = pol[POL_HS] ? hs_a : ~hs_a;
   assign vsync = pol[POL_VS] ? vs_a : ~vs_a;
   assign de    = pol[POL_DE] ? de_a : ~de_a;
   assign field = ilace & (v_cnt >= vs1_st);

   assign last_end     = ilace ? v_end1 : v_end;
   assign flag_line[0] = last_end - CW'(FLAG0_BACKOFF);
   assign flag_line[1] = flag1_line;
   assign line_start   = (h_cnt == '0);

   for (genvar g = 0; g < NF; g++) begin : g_flag
      assign flag_pulse[g] = line_start & (v_cnt == flag_line[g]);
   end

   // R6: field can only change at a line boundary
   a_r6_field_line: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cnt != '0) |-> $stable(field));
endmodule

// File: rtl/raster_timing_top.sv
module raster_timing_top #(
   parameter int CW = rtg_pkg::RTG_CW_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_done,
   input  logic [2*CW-1:0] cfg_h_timing,
   input  logic [2*CW-1:0] cfg_h_active,
   input  logic [2*CW-1:0] cfg_v_timing,
   input  logic [2*CW-1:0] cfg_v_active,
   input  logic [2*CW-1:0] cfg_v_active_f1,
   input  logic [2*CW-1:0] cfg_vsync_f1,
   input  logic [CW-1:0]   cfg_flag1_line,
   input  logic [3:0]      cfg_polarity,
   input  logic            cfg_interlace,
   input  logic            cfg_standby,
   input  logic [1:0]      flag_clr,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic            field,
   output logic [1:0]      flag_pulse,
   output logic [1:0]      flag_sticky
);
   import rtg_pkg::*;

   localparam int NF    = RTG_NUM_FLAGS;
   localparam int CFG_W = 13 * CW + POL_W + 2;

   logic [CFG_W-1:0] cfg_in, cfg_live;
   logic [CW-1:0]    l_htot, l_hsw, l_hst, l_hend, l_vtot, l_vsw, l_vst, l_vend;
   logic [CW-1:0]    l_vst1, l_vend1, l_vs1st, l_vs1end, l_fl1;
   logic [POL_W-1:0] l_pol;
   logic             l_il, l_sb;
   logic [CW-1:0]    h_cnt, v_cnt;
   logic             frame_wrap;
   logic             unused_pol_bit;

   if (CW < 4 || CW > 16) begin : g_cw_chk
      $error("raster_timing_top: CW must lie in 4..16");
   end

   assign unused_pol_bit = cfg_polarity[2];

   assign cfg_in = {cfg_h_timing, cfg_h_active, cfg_v_timing, cfg_v_active,
                    cfg_v_active_f1, cfg_vsync_f1, cfg_flag1_line,
                    cfg_polarity, cfg_interlace, cfg_standby};

   assign {l_htot, l_hsw, l_hst, l_hend, l_vtot, l_vsw, l_vst, l_vend,
           l_vst1, l_vend1, l_vs1st, l_vs1end, l_fl1, l_pol, l_il, l_sb} = cfg_live;

   rtg_shadow #(.W(CFG_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_done   (cfg_done),
      .frame_wrap (frame_wrap),
      .d_in       (cfg_in),
      .q_live     (cfg_live)
   );

   rtg_counters #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .h_tot      (l_htot),
      .v_tot      (l_vtot),
      .h_cnt      (h_cnt),
      .v_cnt      (v_cnt),
      .frame_wrap (frame_wrap)
   );

   rtg_decode #(.CW(CW), .NF(NF)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .h_cnt      (h_cnt),
      .v_cnt      (v_cnt),
      .h_sw       (l_hsw),
      .h_st       (l_hst),
      .h_end      (l_hend),
      .v_sw       (l_vsw),
      .v_st       (l_vst),
      .v_end      (l_vend),
      .v_st1      (l_vst1),
      .v_end1     (l_vend1),
      .vs1_st     (l_vs1st),
      .vs1_end    (l_vs1end),
      .flag1_line (l_fl1),
      .pol        (l_pol),
      .ilace      (l_il),
      .standby    (l_sb),
      .hsync      (hsync),
      .vsync      (vsync),
      .de         (de),
      .field      (field),
      .flag_pulse (flag_pulse)
   );

   for (genvar g = 0; g < NF; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_sticky[g] <= 1'b0;
         else
            flag_sticky[g] <= (flag_sticky[g] & ~flag_clr[g]) | flag_pulse[g];
      end

      // R7 / R8: a flag pulse lasts one cycle on lines longer than one pixel
      a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_pulse[g] && l_htot > CW'(1)) |=> !flag_pulse[g]);
      // R9: a pulse always leaves the sticky bit set
      a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
         flag_pulse[g] |=> flag_sticky[g]);
      // R9: a clear without a pulse drops the bit
      a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_clr[g] && !flag_pulse[g]) |=> !flag_sticky[g]);
   end
endmodule

// File: tb/sim_raster_timing_top.sv
module sim_raster_timing_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;
   localparam int RUN_CYCLES = 760;

   typedef struct {
      int ht, hsw, hst, hend, vt, vsw, vst, vend;
      int vst1, vend1, vs1st, vs1end, fl1, pol, il, sb;
   } tcfg_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_done = 1'b0;
   logic [2*CW-1:0] cfg_h_timing = '0, cfg_h_active = '0, cfg_v_timing = '0;
   logic [2*CW-1:0] cfg_v_active = '0, cfg_v_active_f1 = '0, cfg_vsync_f1 = '0;
   logic [CW-1:0]   cfg_flag1_line = '0;
   logic [3:0]      cfg_polarity = '0;
   logic            cfg_interlace = 1'b0, cfg_standby = 1'b0;
   logic [1:0]      flag_clr = '0;
   logic            hsync, vsync, de, field;
   logic [1:0]      flag_pulse, flag_sticky;

   int    errors = 0;
   int    checks = 0;
   tcfg_t cur, nxt, drv, cz, ca, cb, cc, cd;
   int    n, pend;
   int    es0, es1;
   int    ep0, ep1;

   always #(CLK_PERIOD/2) clk = ~clk;

   raster_timing_top #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
      .cfg_h_timing(cfg_h_timing), .cfg_h_active(cfg_h_active),
      .cfg_v_timing(cfg_v_timing), .cfg_v_active(cfg_v_active),
      .cfg_v_active_f1(cfg_v_active_f1), .cfg_vsync_f1(cfg_vsync_f1),
      .cfg_flag1_line(cfg_flag1_line), .cfg_polarity(cfg_polarity),
      .cfg_interlace(cfg_interlace), .cfg_standby(cfg_standby),
      .flag_clr(flag_clr), .hsync(hsync), .vsync(vsync), .de(de),
      .field(field), .flag_pulse(flag_pulse), .flag_sticky(flag_sticky)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s n=%0d actual=%0d expected=%0d", req, n, act, exp);
      end
   endtask

   function automatic int flen(input tcfg_t c);
      return ((c.ht < 1) ? 1 : c.ht) * ((c.vt < 1) ? 1 : c.vt);
   endfunction

   function automatic logic [2*CW-1:0] pk(input int hi, input int lo);
      return {16'(hi), 16'(lo)};
   endfunction

   task automatic drive_cfg(input tcfg_t c);
      cfg_h_timing    = pk(c.ht, c.hsw);
      cfg_h_active    = pk(c.hst, c.hend);
      cfg_v_timing    = pk(c.vt, c.vsw);
      cfg_v_active    = pk(c.vst, c.vend);
      cfg_v_active_f1 = pk(c.vst1, c.vend1);
      cfg_vsync_f1    = pk(c.vs1st, c.vs1end);
      cfg_flag1_line  = 16'(c.fl1);
      cfg_polarity    = 4'(c.pol);
      cfg_interlace   = c.il[0];
      cfg_standby     = c.sb[0];
      cfg_done        = 1'b1;
      drv             = c;
   endtask

   // Expected outputs for the current pixel, from the requirement rules
   task automatic check_cycle();
      int htn, h, v, hs, vs, dd, fd, fend, f0;
      htn  = (cur.ht < 1) ? 1 : cur.ht;
      h    = n % htn;
      v    = n / htn;
      hs   = (h < cur.hsw) && !cur.sb;                                   // R2
      vs   = ((v < cur.vsw) || (cur.il && v >= cur.vs1st && v < cur.vs1end))
             && !cur.sb;                                                 // R3 R5
      dd   = (h >= cur.hst && h < cur.hend) &&
             ((v >= cur.vst && v < cur.vend) ||
              (cur.il && v >= cur.vst1 && v < cur.vend1)) && !cur.sb;    // R4 R5 R11
      fd   = cur.il && (v >= cur.vs1st);                                 // R6
      fend = cur.il ? cur.vend1 : cur.vend;
      f0   = (fend - 3) & 16'hFFFF;                                      // R7
      ep0  = (h == 0) && (v == f0);
      ep1  = (h == 0) && (v == cur.fl1);                                 // R8
      chk("R2 R10 R12 hsync", int'(hsync), cur.pol[0] ? hs : !hs);
      chk("R3 R5 R10 vsync", int'(vsync), cur.pol[1] ? vs : !vs);
      chk("R4 R11 R10 de", int'(de), cur.pol[3] ? dd : !dd);
      chk("R6 field", int'(field), fd);
      chk("R7 flag0 pulse", int'(flag_pulse[0]), ep0);
      chk("R8 flag1 pulse", int'(flag_pulse[1]), ep1);
      chk("R9 sticky0", int'(flag_sticky[0]), es0);
      chk("R9 sticky1", int'(flag_sticky[1]), es1);
   endtask

   // Model update at the rising edge (R12 shadow and frame wrap)
   task automatic advance();
      int wrapnow;
      wrapnow = (n + 1 == flen(cur));
      if (wrapnow && pend) cur = nxt;
      if (cfg_done) nxt = drv;
      pend = cfg_done || (pend && !wrapnow);
      es0  = (es0 && !flag_clr[0]) || ep0;
      es1  = (es1 && !flag_clr[1]) || ep1;
      n    = wrapnow ? 0 : n + 1;
   endtask

   initial begin
      cz = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};
      // progressive: 10x8, hsync 2, de h[4,8) v[2,6), flag1 line 4
      ca = '{10,2,4,8,8,1,2,6,0,0,0,0,4,4'b1011,0,0};
      // interlaced: 10x11, field-1 de v[8,10), field-1 vsync v[5,6)
      cb = '{10,2,3,9,11,1,2,4,8,10,5,6,9,4'b1000,1,0};
      // standby with all polarities low
      cc = '{10,2,4,8,8,1,2,6,0,0,0,0,4,4'b0000,0,1};
      // mixed polarity, bit 2 set and ignored
      cd = '{10,3,4,8,8,2,2,6,0,0,0,0,7,4'b1110,0,0};
      cur = cz; nxt = cz; drv = cz;
      n = 0; pend = 0; es0 = 0; es1 = 0; ep0 = 0; ep1 = 0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 hsync idle", int'(hsync), 1);
      chk("R1 vsync idle", int'(vsync), 1);
      chk("R1 de idle", int'(de), 1);
      chk("R1 field", int'(field), 0);
      chk("R1 sticky", int'(flag_sticky), 0);
      rst_n = 1'b1;

      for (int t = 0; t < RUN_CYCLES; t++) begin
         check_cycle();
         cfg_done = 1'b0;
         flag_clr = 2'b00;
         if (t == 3)   drive_cfg(ca);
         if (t == 30)  drive_cfg(cb);   // R12: deferred to end of frame
         if (t == 260) drive_cfg(cc);
         if (t == 420) drive_cfg(cd);
         if (t == 600) drive_cfg(ca);
         if (t % 37 == 5)  flag_clr[0] = 1'b1;
         if (t % 29 == 11) flag_clr[1] = 1'b1;
         if (t % 61 == 0)  flag_clr = 2'b11;
         @(posedge clk);
         advance();
         @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (RUN_CYCLES + 200) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule